// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides whether an 8051-class core and its peripherals receive a clock. The CPU sets the mode by writing one 8-bit power control register over a simple SFR write bus. The block then drives one clock enable for the CPU core and one for the peripheral group, and it reports the current mode on a two-bit status output. The register's six remaining bits are passed straight out as level signals. These are two double-baud selects, a low-voltage-reset disable, an ADC interrupt enable, and receive/transmit clock selects for the second UART.

There are three modes: run, idle and power-down. Idle stops only the CPU clock, and any interrupt request or reset ends it. Power-down stops the clock for the CPU and for every peripheral, and only reset ends it. In both low-power modes the register contents are kept, and the voltage-detect enable keeps following the register. While the CPU is halted it cannot issue writes, so the block ignores the write strobe in idle and in power-down.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the register is 0x00. All six pass-through bits are 0, the status is 00 (run), `cpu_clk_en` and `per_clk_en` are 1, and `lvd_en` is 1.
- R2: In run mode, a write strobe to address 0x87 loads the register at that clock edge. The pass-through outputs then reflect data bits 7 (`dbl_baud0`), 6 (`dbl_baud1`), 5 (`lvr_dis`), 4 (`adc_irq_en`), 3 (`u2_rx_clk`) and 2 (`u2_tx_clk`). A write to any other address changes nothing.
- R3: A run-mode write to 0x87 with bit 0 = 1 and bit 1 = 0 gives status 01 (idle) from the next edge. In idle, `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R4: In idle, a high `irq` for one cycle clears the idle bit at the next edge. The status returns to 00 and `cpu_clk_en` to 1, and the other register bits are unchanged.
- R5: A run-mode write to 0x87 with bit 1 = 1 gives status 10 (power-down) from the next edge, with `cpu_clk_en` = 0 and `per_clk_en` = 0.
- R6: A write with both bit 0 and bit 1 set gives status 10; power-down takes precedence.
- R7: In power-down, `irq` has no effect. The status stays 10 until reset.
- R8: In idle and in power-down, write strobes are ignored. The pass-through bits and the status are unchanged.
- R9: `lvd_en` equals the inverse of `lvr_dis` in every mode, including power-down.
- R10: `irq` has no effect in run mode. If a write that enters idle coincides with `irq`, the block enters idle, because `irq` only wakes from idle.
- R11: Asserting reset in idle or power-down returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| irq | input | 1 | Enabled interrupt request (level) |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral group clock enable |
| lvd_en | output | 1 | Low-voltage detector enable |
| pwr_mode | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| dbl_baud0 | output | 1 | Double baud rate, first UART |
| dbl_baud1 | output | 1 | Double baud rate, second UART |
| lvr_dis | output | 1 | Low-voltage reset disable |
| adc_irq_en | output | 1 | ADC interrupt enable |
| u2_rx_clk | output | 1 | Second UART receive clock select |
| u2_tx_clk | output | 1 | Second UART transmit clock select |

## Verification
Two events can arrive in the same cycle: a register write that requests idle and an interrupt request. The bench applies both in one cycle and expects idle, since the interrupt is only a wake event once idle is active. It holds the interrupt for the following cycle and expects run again with the non-power bits intact. It also pairs the interrupt with power-down, and pairs a write strobe with each low-power mode, to show that neither disturbs the held state.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_PDOWN = 2'b10
  } pwr_mode_e;

  localparam int CTL_W   = 8;
  localparam int IDL_BIT = 0;
  localparam int PD_BIT  = 1;

  // Power-down bit takes precedence over idle bit.
  function automatic pwr_mode_e mode_of(input logic [CTL_W-1:0] ctl);
    if (ctl[PD_BIT])       return MODE_PDOWN;
    else if (ctl[IDL_BIT]) return MODE_IDLE;
    else                   return MODE_RUN;
  endfunction

  // Next register value: wake clears idle bit, otherwise an accepted write loads.
  function automatic logic [CTL_W-1:0] ctl_next(input logic [CTL_W-1:0] cur,
                                               input logic             wake,
                                               input logic             wr_ok,
                                               input logic [CTL_W-1:0] wdata);
    logic [CTL_W-1:0] nxt;
    nxt = cur;
    if (wake)       nxt[IDL_BIT] = 1'b0;
    else if (wr_ok) nxt = wdata;
    return nxt;
  endfunction

endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [CTL_W-1:0]  sfr_wdata,
  input  logic              irq,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              wr_hit,
  output logic              wake_evt
);

  pwr_mode_e mode_now;

  assign mode_now = mode_of(ctl_q);
  // Writes only land while the CPU is running.
  assign wr_hit   = sfr_wr && (sfr_addr == CTL_ADDR) && (mode_now == MODE_RUN);
  assign wake_evt = (mode_now == MODE_IDLE) && irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_next(ctl_q, wake_evt, wr_hit, sfr_wdata);
  end

  p_enter_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sfr_wdata[IDL_BIT] && !sfr_wdata[PD_BIT]) |=> (mode_of(ctl_q) == MODE_IDLE));

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (!ctl_q[IDL_BIT] && $stable(ctl_q[CTL_W-1:2])));

  p_pd_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sfr_wdata[PD_BIT]) |=> (mode_of(ctl_q) == MODE_PDOWN));

  p_pd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_PDOWN) |=> (mode_of(ctl_q) == MODE_PDOWN));

  p_halted_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_now != MODE_RUN) && sfr_wr) |=> $stable(ctl_q[CTL_W-1:PD_BIT]));

  p_run_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_now == MODE_RUN) && irq && !wr_hit) |=> $stable(ctl_q));

endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_mode_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_q,
  output logic [1:0]       pwr_mode,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             lvd_en,
  output logic [5:0]       pass_bits
);

  pwr_mode_e mode;

  always_comb begin
    mode       = mode_of(ctl_q);
    pwr_mode   = mode;
    cpu_clk_en = (mode == MODE_RUN);
    per_clk_en = (mode != MODE_PDOWN);
    lvd_en     = !ctl_q[5];
    pass_bits  = ctl_q[CTL_W-1:2];
  end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              irq,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              lvd_en,
  output logic [1:0]        pwr_mode,
  output logic              dbl_baud0,
  output logic              dbl_baud1,
  output logic              lvr_dis,
  output logic              adc_irq_en,
  output logic              u2_rx_clk,
  output logic              u2_tx_clk
);

  logic [CTL_W-1:0] ctl_q;
  logic             wr_hit;
  logic             wake_evt;
  logic [5:0]       pass_bits;

  pwr_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sfr_wr   (sfr_wr),
    .sfr_addr (sfr_addr),
    .sfr_wdata(sfr_wdata),
    .irq      (irq),
    .ctl_q    (ctl_q),
    .wr_hit   (wr_hit),
    .wake_evt (wake_evt)
  );

  pwr_mode_dec u_dec (
    .ctl_q     (ctl_q),
    .pwr_mode  (pwr_mode),
    .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en),
    .lvd_en    (lvd_en),
    .pass_bits (pass_bits)
  );

  assign {dbl_baud0, dbl_baud1, lvr_dis, adc_irq_en, u2_rx_clk, u2_tx_clk} = pass_bits;

  p_idle_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == MODE_IDLE) |-> (per_clk_en && !cpu_clk_en));

  p_wake_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (cpu_clk_en && pwr_mode == MODE_RUN));

  p_pd_clocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == MODE_PDOWN) |-> (!per_clk_en && !cpu_clk_en));

  p_lvd_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_en != lvr_dis);

endmodule

// File: tb/pwr_mode_ctl_bench.sv
module pwr_mode_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       irq = 1'b0;
  logic       cpu_clk_en, per_clk_en, lvd_en;
  logic [1:0] pwr_mode;
  logic       dbl_baud0, dbl_baud1, lvr_dis, adc_irq_en, u2_rx_clk, u2_tx_clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctl u_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .irq(irq), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .lvd_en(lvd_en), .pwr_mode(pwr_mode),
    .dbl_baud0(dbl_baud0), .dbl_baud1(dbl_baud1), .lvr_dis(lvr_dis),
    .adc_irq_en(adc_irq_en), .u2_rx_clk(u2_rx_clk), .u2_tx_clk(u2_tx_clk)
  );

  // Vector fields: wr, addr, wdata, irq, expected mode, expected pass bits [7:2]
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'h87, 8'hA4, 1'b0, 2'b00, 6'b101001},  // R2 load
    {1'b1, 8'h86, 8'hFF, 1'b0, 2'b00, 6'b101001},  // R2 other address
    {1'b0, 8'h87, 8'h00, 1'b1, 2'b00, 6'b101001},  // R10 irq in run
    {1'b1, 8'h87, 8'h51, 1'b0, 2'b01, 6'b010100},  // R3 enter idle
    {1'b1, 8'h87, 8'h00, 1'b0, 2'b01, 6'b010100},  // R8 write in idle
    {1'b0, 8'h00, 8'h00, 1'b1, 2'b00, 6'b010100},  // R4 wake
    {1'b0, 8'h00, 8'h00, 1'b0, 2'b00, 6'b010100},  // R4 stays run
    {1'b1, 8'h87, 8'h3D, 1'b1, 2'b01, 6'b001111},  // R10 write+irq same cycle
    {1'b0, 8'h00, 8'h00, 1'b1, 2'b00, 6'b001111},  // R4 wake again
    {1'b1, 8'h87, 8'hC3, 1'b0, 2'b10, 6'b110000},  // R5 R6 both bits
    {1'b0, 8'h00, 8'h00, 1'b1, 2'b10, 6'b110000},  // R7 irq in pd
    {1'b1, 8'h87, 8'h00, 1'b0, 2'b10, 6'b110000}   // R8 write in pd
  };

  task automatic check(input string req, input logic [1:0] exp_mode, input logic [5:0] exp_bits);
    logic [5:0] act_bits;
    logic [2:0] act_en, exp_en;
    act_bits = {dbl_baud0, dbl_baud1, lvr_dis, adc_irq_en, u2_rx_clk, u2_tx_clk};
    act_en   = {cpu_clk_en, per_clk_en, lvd_en};
    exp_en   = {exp_mode == 2'b00, exp_mode != 2'b10, !exp_bits[3]};  // R9 lvd = ~bit5
    checks++;
    if (pwr_mode !== exp_mode || act_bits !== exp_bits || act_en !== exp_en) begin
      failures++;
      $display("FAIL %s: mode=%b bits=%b en=%b expected mode=%b bits=%b en=%b",
               req, pwr_mode, act_bits, act_en, exp_mode, exp_bits, exp_en);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic i);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d; irq = i;
    @(negedge clk);
    sfr_wr = 1'b0; irq = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1", 2'b00, 6'b000000);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][25], VEC[k][24:17], VEC[k][16:9], VEC[k][8]);
      check($sformatf("R2-R10 vec%0d", k), VEC[k][7:6], VEC[k][5:0]);
    end

    // R11 reset from power-down
    do_reset();
    check("R11 from pd", 2'b00, 6'b000000);

    // R9 power-down with low-voltage reset disabled
    drive(1'b1, 8'h87, 8'h22, 1'b0);
    check("R9 pd lvr_dis", 2'b10, 6'b001000);
    drive(1'b0, 8'h00, 8'h00, 1'b1);
    check("R7 R9 pd hold", 2'b10, 6'b001000);

    // R11 reset from idle
    do_reset();
    drive(1'b1, 8'h87, 8'h91, 1'b0);
    check("R3 idle", 2'b01, 6'b100100);
    do_reset();
    check("R11 from idle", 2'b00, 6'b000000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule